// File: doc/BRIEF.md
# Receive Channel Routing Multiplexer

This block sits between a bank of four digitized receive streams and up to four complex downconverters, and between those downconverters and a single 16-bit host link. On the input side it picks, for every downconverter, which converter input feeds its I port and which feeds its Q port. A single global flag can instead tie every Q port to zero, for real-only reception. The routed samples are registered on each converter strobe and presented with a one-cycle valid pulse.

On the output side, every result strobe captures the I/Q results of all downconverters. The block then plays out channel 0 I, channel 0 Q, channel 1 I, channel 1 Q and so on, one 16-bit word per clock, for the configured number of complex channels (1, 2 or 4). A 32-bit configuration word controls everything. It is loaded into the active setting only at the clock edge where a result group is accepted, so a group is never split between two settings and the routing only changes on a sample-period boundary.

Top module: `rx_route_mux`

## Requirements
- R1: After reset, out_valid and ddc_valid are 0 and ddc_i/ddc_q are all zero. The active setting is the all-zero word, so the first converter strobe before any result group routes converter input 0 to every I and every Q port.
- R2: Configuration bits [4c+5:4c+4] (c = 0..3) select the I source of channel c; value k routes converter input k (adc_data[16k+15:16k]). The routed values appear on ddc_i with ddc_valid high in the cycle after an adc_strobe cycle.
- R3: When bit 3 is 0, configuration bits [4c+7:4c+6] select the Q source of channel c in the same way and drive ddc_q.
- R4: When bit 3 is 1, every channel's ddc_q is zero regardless of the Q select fields.
- R5: Bits [2:0] give the complex channel count; values 1, 2 and 4 produce groups of 2, 4 and 8 words. Word 2c is channel c I (res_i[16c+15:16c]) and word 2c+1 is channel c Q.
- R6: Channel count values 0, 3, 5, 6 and 7 are treated as 1, giving groups of 2 words.
- R7: Word 0 of a group is on out_data with out_valid high in the cycle after the accepting clock edge. The remaining words follow on consecutive cycles, and out_valid is low in the cycle after the last word unless a new group was accepted.
- R8: A res_strobe arriving while a group is being played out, before its last word, is ignored. The running group continues unchanged and no new group follows.
- R9: A change of cfg_word takes effect only at the edge where a result group is accepted. Between groups, routing keeps the last loaded setting, and ddc_i/ddc_q hold their value in cycles without adc_strobe.
- R10: Bits [31:20] of the configuration word have no effect on routing or on the group length.
- R11: A res_strobe in the cycle of a group's last word is accepted. The next group starts on the following cycle with no idle gap, using the cfg_word present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Pending configuration word, loaded at group acceptance |
| adc_strobe | input | 1 | New converter samples present on adc_data |
| adc_data | input | 64 | Four 16-bit converter samples, input k in bits [16k+15:16k] |
| res_strobe | input | 1 | New downconverter results present on res_i/res_q |
| res_i | input | 64 | Downconverter I results, channel c in bits [16c+15:16c] |
| res_q | input | 64 | Downconverter Q results, channel c in bits [16c+15:16c] |
| ddc_i | output | 64 | Routed I inputs for the four downconverters |
| ddc_q | output | 64 | Routed Q inputs for the four downconverters |
| ddc_valid | output | 1 | One-cycle pulse marking new routed inputs |
| out_valid | output | 1 | Serialized word valid |
| out_data | output | 16 | Serialized word |

## Verification
The hardest situations to reach from the ports depend on exact placement of a result strobe relative to a running group. A strobe one word before the end must be dropped. A strobe on the last word must start a new group with no gap. The directed tests put the strobe at the third word of an eight-word group with altered result data, then chain a second group from the last word of a first one under a different channel count, and compare every word. A configuration change with no result strobe is followed by a converter strobe, to show that routing still follows the old setting.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CFG_W    = 32;
  localparam int SEL_W    = 2;
  localparam int CNT_W    = 3;

  // number of complex channels from the count field; illegal codes give 1
  function automatic logic [3:0] chan_count(input logic [CNT_W-1:0] f);
    case (f)
      3'd1, 3'd2, 3'd4: chan_count = {1'b0, f};
      default:          chan_count = 4'd1;
    endcase
  endfunction

  // words per group: two per complex channel
  function automatic logic [3:0] group_words(input logic [CNT_W-1:0] f);
    group_words = chan_count(f) << 1;
  endfunction

  function automatic logic [SEL_W-1:0] i_field(input logic [CFG_W-1:0] w, input int c);
    i_field = w[4*c+4 +: SEL_W];
  endfunction

  function automatic logic [SEL_W-1:0] q_field(input logic [CFG_W-1:0] w, input int c);
    q_field = w[4*c+6 +: SEL_W];
  endfunction

  function automatic logic zero_flag(input logic [CFG_W-1:0] w);
    zero_flag = w[3];
  endfunction
endpackage

// File: rtl/rxr_cfg_hold.sv
module rxr_cfg_hold #(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_active
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_active <= '0;
    else if (load) cfg_active <= cfg_in;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_active));
endmodule

// File: rtl/rxr_route.sv
module rxr_route
  import rxr_pkg::*;
#(
  parameter int SW   = 16,
  parameter int NCH  = 4,
  parameter int NSRC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_strobe,
  input  logic [NSRC*SW-1:0] adc_data,
  input  logic [CFG_W-1:0]  cfg,
  output logic [NCH*SW-1:0] ddc_i,
  output logic [NCH*SW-1:0] ddc_q,
  output logic              ddc_valid
);
  logic [SW-1:0] src    [NSRC];
  logic [SW-1:0] pick_i [NCH];
  logic [SW-1:0] pick_q [NCH];
  logic          q_zero;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg[CFG_W-1:20], cfg[2:0]};
  assign q_zero     = zero_flag(cfg);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign src[k] = adc_data[k*SW +: SW];
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      pick_i[c] = src[i_field(cfg, c)];
      pick_q[c] = q_zero ? '0 : src[q_field(cfg, c)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddc_i     <= '0;
      ddc_q     <= '0;
      ddc_valid <= 1'b0;
    end else begin
      ddc_valid <= adc_strobe;
      if (adc_strobe) begin
        for (int c = 0; c < NCH; c++) begin
          ddc_i[c*SW +: SW] <= pick_i[c];
          ddc_q[c*SW +: SW] <= pick_q[c];
        end
      end
    end
  end

  // R4
  zero_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_strobe && q_zero) |=> (ddc_q == '0));

  // R9
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_strobe |=> ($stable(ddc_i) && $stable(ddc_q) && !ddc_valid));
endmodule

// File: rtl/rxr_interleave.sv
module rxr_interleave #(
  parameter int SW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_strobe,
  input  logic [NCH*SW-1:0] res_i,
  input  logic [NCH*SW-1:0] res_q,
  input  logic [3:0]        words_req,
  output logic              accept,
  output logic              out_valid,
  output logic [SW-1:0]     out_data
);
  localparam int NW = 2 * NCH;
  localparam int IW = $clog2(NW);

  logic [SW-1:0] wbuf [NW];
  logic [IW-1:0] idx;
  logic [IW:0]   total;
  logic          busy;
  logic          last_word;

  assign last_word = busy && ({1'b0, idx} == total - 1'b1);
  assign accept    = res_strobe && (!busy || last_word);
  assign out_valid = busy;
  assign out_data  = busy ? wbuf[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      total <= '0;
      for (int w = 0; w < NW; w++) wbuf[w] <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      total <= words_req[IW:0];
      for (int c = 0; c < NCH; c++) begin
        wbuf[2*c]   <= res_i[c*SW +: SW];
        wbuf[2*c+1] <= res_q[c*SW +: SW];
      end
    end else if (busy) begin
      if (last_word) busy <= 1'b0;
      else           idx  <= idx + 1'b1;
    end
  end

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < total));

  // R6
  group_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(total) == 1 && total >= 2));

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_word && res_strobe) |=> (busy && idx == $past(idx) + 1'b1));

  // R11
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && res_strobe) |=> (busy && idx == '0));
endmodule

// File: rtl/rx_route_mux.sv
module rx_route_mux
  import rxr_pkg::*;
#(
  parameter int SW   = 16,
  parameter int NCH  = 4,
  parameter int NSRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cfg_word,
  input  logic               adc_strobe,
  input  logic [NSRC*SW-1:0] adc_data,
  input  logic               res_strobe,
  input  logic [NCH*SW-1:0]  res_i,
  input  logic [NCH*SW-1:0]  res_q,
  output logic [NCH*SW-1:0]  ddc_i,
  output logic [NCH*SW-1:0]  ddc_q,
  output logic               ddc_valid,
  output logic               out_valid,
  output logic [SW-1:0]      out_data
);
  logic             grp_accept;
  logic [CFG_W-1:0] cfg_active;
  logic [3:0]       words_req;

  assign words_req = group_words(cfg_word[CNT_W-1:0]);

  rxr_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(grp_accept),
    .cfg_in(cfg_word), .cfg_active(cfg_active)
  );

  rxr_route #(.SW(SW), .NCH(NCH), .NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n), .adc_strobe(adc_strobe), .adc_data(adc_data),
    .cfg(cfg_active), .ddc_i(ddc_i), .ddc_q(ddc_q), .ddc_valid(ddc_valid)
  );

  rxr_interleave #(.SW(SW), .NCH(NCH)) u_ilv (
    .clk(clk), .rst_n(rst_n), .res_strobe(res_strobe), .res_i(res_i),
    .res_q(res_q), .words_req(words_req), .accept(grp_accept),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/rx_route_mux_tb.sv
`timescale 1ns/1ps
module rx_route_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        adc_strobe = 1'b0;
  logic [63:0] adc_data = '0;
  logic        res_strobe = 1'b0;
  logic [63:0] res_i = '0;
  logic [63:0] res_q = '0;
  logic [63:0] ddc_i, ddc_q;
  logic        ddc_valid, out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_route_mux u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .adc_strobe(adc_strobe),
    .adc_data(adc_data), .res_strobe(res_strobe), .res_i(res_i), .res_q(res_q),
    .ddc_i(ddc_i), .ddc_q(ddc_q), .ddc_valid(ddc_valid),
    .out_valid(out_valid), .out_data(out_data)
  );

  // configuration vectors and expected group lengths
  localparam logic [31:0] VCFG [8] = '{
    32'h0000_0001, 32'h0000_0392, 32'h0001_8E7C, 32'h0001_8E74,
    32'h0000_00A0, 32'h0000_0053, 32'hFFF0_0007, 32'h0000_0036
  };
  localparam int VLEN [8] = '{2, 4, 8, 8, 2, 2, 2, 2};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [31:0] cfg);
    int n = int'(cfg & 32'h7);
    if (n == 1 || n == 2 || n == 4) return 2 * n;
    return 2;
  endfunction

  function automatic logic [15:0] adc_val(input logic [15:0] seed, input int k);
    return seed + 16'(k + 1) * 16'h1111;
  endfunction

  function automatic logic [15:0] res_word(input logic [15:0] base, input int j);
    return base + 16'(j) * 16'h0101;
  endfunction

  task automatic set_res(input logic [15:0] base);
    for (int c = 0; c < 4; c++) begin
      res_i[c*16 +: 16] = res_word(base, 2*c);
      res_q[c*16 +: 16] = res_word(base, 2*c+1);
    end
  endtask

  task automatic start_group(input logic [31:0] cfg, input logic [15:0] base);
    cfg_word = cfg;
    set_res(base);
    res_strobe = 1'b1;
    @(negedge clk);
    res_strobe = 1'b0;
  endtask

  // checks the words of an accepted group; optionally injects or chains a strobe
  task automatic play_words(input logic [31:0] cfg, input logic [15:0] base, input int inj,
                            input bit chain, input logic [31:0] cfg2, input logic [15:0] base2,
                            input string req);
    int n = exp_len(cfg);
    for (int j = 0; j < n; j++) begin
      chk(out_valid === 1'b1 && out_data === res_word(base, j), req,
          {47'd0, out_valid, out_data}, {47'd0, 1'b1, res_word(base, j)});
      if (j == inj) begin
        set_res(16'hDEAD);
        res_strobe = 1'b1;
      end else if (chain && j == n - 1) begin
        cfg_word = cfg2;
        set_res(base2);
        res_strobe = 1'b1;
      end else begin
        res_strobe = 1'b0;
      end
      @(negedge clk);
    end
    res_strobe = 1'b0;
    if (!chain) chk(out_valid === 1'b0, {req, " R7 end"}, {63'd0, out_valid}, 64'd0);
  endtask

  task automatic adc_check(input logic [31:0] cfg, input logic [15:0] seed, input string req);
    logic [63:0] ei, eq;
    for (int k = 0; k < 4; k++) adc_data[k*16 +: 16] = adc_val(seed, k);
    for (int c = 0; c < 4; c++) begin
      ei[c*16 +: 16] = adc_val(seed, int'((cfg >> (4*c+4)) & 32'h3));
      eq[c*16 +: 16] = cfg[3] ? 16'h0 : adc_val(seed, int'((cfg >> (4*c+6)) & 32'h3));
    end
    adc_strobe = 1'b1;
    @(negedge clk);
    adc_strobe = 1'b0;
    chk(ddc_valid === 1'b1, {req, " valid"}, {63'd0, ddc_valid}, 64'd1);
    chk(ddc_i === ei, {req, " I"}, ddc_i, ei);
    chk(ddc_q === eq, {req, " Q"}, ddc_q, eq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk(ddc_valid === 1'b0, "R1 ddc_valid", {63'd0, ddc_valid}, 64'd0);
    chk(ddc_i === 64'd0 && ddc_q === 64'd0, "R1 ddc zero", ddc_i | ddc_q, 64'd0);
    // R1 default routing: input 0 everywhere, even with a pending cfg
    cfg_word = 32'h0001_8E74;
    adc_check(32'h0, 16'h0300, "R1 default route");

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 8; v++) begin
      chk(exp_len(VCFG[v]) == VLEN[v], "R5 table", 64'(exp_len(VCFG[v])), 64'(VLEN[v]));
      start_group(VCFG[v], 16'h1000 + 16'(v) * 16'h0010);
      play_words(VCFG[v], 16'h1000 + 16'(v) * 16'h0010, -1, 1'b0, 32'h0, 16'h0, "R5 R6 group");
      adc_check(VCFG[v], 16'h0040 + 16'(v), "R2 R3 R4 route");
    end

    // R10: reserved bits set, same behaviour as the clean word
    start_group(32'hABC0_0392, 16'h5000);
    play_words(32'h0000_0392, 16'h5000, -1, 1'b0, 32'h0, 16'h0, "R10 group");
    adc_check(32'h0000_0392, 16'h0777, "R10 route");

    // R9: new cfg without result strobe leaves routing alone
    cfg_word = 32'h0001_8E7C;
    @(negedge clk);
    adc_check(32'h0000_0392, 16'h0123, "R9 route kept");
    adc_data = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    chk(ddc_valid === 1'b0, "R9 no strobe valid", {63'd0, ddc_valid}, 64'd0);
    adc_check(32'h0000_0392, 16'h0500, "R9 route after idle");

    // R8: strobe at word 2 of an eight-word group is dropped
    start_group(32'h0001_8E74, 16'h2000);
    play_words(32'h0001_8E74, 16'h2000, 2, 1'b0, 32'h0, 16'h0, "R8 ignore");
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R8 no extra group", {63'd0, out_valid}, 64'd0);

    // R11: chain a two-channel group from the last word of a one-channel group
    start_group(32'h0000_0001, 16'h3000);
    play_words(32'h0000_0001, 16'h3000, -1, 1'b1, 32'h0000_0392, 16'h4000, "R11 first");
    play_words(32'h0000_0392, 16'h4000, -1, 1'b0, 32'h0, 16'h0, "R11 chained");

    // R7: group with idle cycles around it stays low before and after
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 idle", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule